// File: doc/BRIEF.md
# Bridge-Tied Dual PWM Audio Modulator

This block converts a stream of 8-bit offset-binary audio samples into two pulse-width-modulated waveforms that drive the two halves of a bridge-tied load. One up-counter runs from zero to a programmable period limit and then wraps, so both outputs share one time base and switch on the same clock edges. Channel A's compare value is the sample scaled onto the counter range. Channel B's value is the period limit minus A's value. A positive swing therefore widens A's pulse and narrows B's. At midscale both channels carry the same value, so the load sees no differential drive.

A new sample is offered with a one-cycle valid strobe and is held in a shadow register. At the next wrap the compare values are recomputed from that sample and the period limit, and copied into the active registers together with the limit itself. The running period is never disturbed. A polarity input selects which side of the compare point is high. A one-cycle period-start pulse marks every wrap and can be used to request the next sample.

Top module: `btl_pwm_mod`

## Requirements
- R1: With a period limit L on `top_i`, the counter runs 0..L, so one period lasts L+1 cycles. `top_i` is taken only at a wrap. `period_start_o` is high for exactly one cycle, the first cycle of each period.
- R2: Channel A's compare value is floor(s*(L+1)/256) for sample s. At L=255 it equals s.
- R3: Channel B's compare value is L minus channel A's value.
- R4: With `pol_i`=0, a channel is high while count < compare and low from the match to L. A compare of L keeps the output high for the whole period (L+1 high cycles). A compare of 0 keeps it low for the whole period.
- R5: With `pol_i`=1, each output is the exact complement of its `pol_i`=0 level, so it is high for (L+1) minus the `pol_i`=0 high count.
- R6: With sample 128 and an even L, both outputs are equal in every cycle, and their edges fall on the same clock.
- R7: A sample strobed by `smp_vld_i` changes nothing in the period that is running. It takes effect from the next wrap onward.
- R8: During reset both outputs and `period_start_o` are low. The sample shadow resets to midscale (128), so with no sample offered the outputs come up identical.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_i | input | 8 | Offset-binary audio sample, 128 = silence |
| smp_vld_i | input | 1 | Strobe that captures `smp_i` into the shadow register |
| top_i | input | 8 | Period limit L, loaded at each wrap |
| pol_i | input | 1 | Output polarity: 0 = high before the match, 1 = inverted |
| pwm_a_o | output | 1 | Bridge half A drive |
| pwm_b_o | output | 1 | Bridge half B drive |
| period_start_o | output | 1 | One-cycle pulse in the first cycle of each period |

## Verification
The hardest case to reach from the ports is a sample that arrives part-way through a period. Its compare update must wait for the wrap and must not cut the running pulse short. The bench locks onto `period_start_o`, counts cycles into the period, strobes a new sample well before the wrap, and then checks two things. The period in flight must keep the old high counts, and the following period must carry the new ones. The extreme compare values, 0 and L, are reached with full-scale samples in both polarities, where a runt pulse would show up as a count that is one cycle off.

// File: rtl/btl_pwm_pkg.sv
package btl_pwm_pkg;

    parameter int unsigned CNT_W  = 8;
    parameter int unsigned SMP_W  = 8;
    localparam int unsigned PROD_W = CNT_W + SMP_W + 1;
    localparam logic [SMP_W-1:0] SMP_MID = SMP_W'(1) << (SMP_W - 1);

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [SMP_W-1:0] smp_t;

    typedef enum logic {
        POL_HIGH_FIRST = 1'b0,
        POL_LOW_FIRST  = 1'b1
    } pol_e;

    // Map a sample onto 0..top: floor(s * (top + 1) / 2^SMP_W)
    function automatic cnt_t scale_sample(smp_t s, cnt_t top);
        logic [PROD_W-1:0] prod;
        prod = PROD_W'(s) * (PROD_W'(top) + PROD_W'(1));
        return prod[SMP_W +: CNT_W];
    endfunction

    // Output level for one count; compare == top means high for the whole period
    function automatic logic chan_level(cnt_t cnt, cnt_t cmp, cnt_t top, pol_e pol);
        logic hi;
        hi = (cmp == top) ? 1'b1 : (cnt < cmp);
        return hi ^ pol;
    endfunction

endpackage

// File: rtl/btl_pwm_timebase.sv
module btl_pwm_timebase
    import btl_pwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cnt_t top_i,
    output cnt_t cnt_o,
    output cnt_t top_o,
    output cnt_t cnt_nxt_o,
    output cnt_t top_nxt_o,
    output logic wrap_o,
    output logic start_o
);

    typedef struct packed {
        cnt_t cnt;
        cnt_t top;
        logic start;
    } tb_state_t;

    tb_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        if (s_q.cnt == s_q.top) begin
            s_d.cnt   = '0;
            s_d.top   = top_i;
            s_d.start = 1'b1;
        end else begin
            s_d.cnt = s_q.cnt + cnt_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o     = s_q.cnt;
    assign top_o     = s_q.top;
    assign cnt_nxt_o = s_d.cnt;
    assign top_nxt_o = s_d.top;
    assign wrap_o    = (s_q.cnt == s_q.top);
    assign start_o   = s_q.start;

endmodule

// File: rtl/btl_pwm_shadow.sv
module btl_pwm_shadow
    import btl_pwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  smp_t smp_i,
    input  logic vld_i,
    input  logic wrap_i,
    input  cnt_t top_nxt_i,
    output cnt_t cmp_a_o,
    output cnt_t cmp_b_o,
    output cnt_t cmp_a_nxt_o,
    output cnt_t cmp_b_nxt_o
);

    typedef struct packed {
        smp_t smp;
        cnt_t cmp_a;
        cnt_t cmp_b;
    } sh_state_t;

    sh_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (vld_i) begin
            s_d.smp = smp_i;
        end
        // Active values change only at the period boundary, from the held sample
        if (wrap_i) begin
            s_d.cmp_a = scale_sample(s_q.smp, top_nxt_i);
            s_d.cmp_b = top_nxt_i - s_d.cmp_a;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.smp   <= SMP_MID;
            s_q.cmp_a <= '0;
            s_q.cmp_b <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmp_a_o     = s_q.cmp_a;
    assign cmp_b_o     = s_q.cmp_b;
    assign cmp_a_nxt_o = s_d.cmp_a;
    assign cmp_b_nxt_o = s_d.cmp_b;

endmodule

// File: rtl/btl_pwm_chan.sv
module btl_pwm_chan
    import btl_pwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cnt_t cnt_nxt_i,
    input  cnt_t cmp_nxt_i,
    input  cnt_t top_nxt_i,
    input  pol_e pol_i,
    output logic pwm_o
);

    logic lvl_d, lvl_q;

    // Level is derived from next-state values so the registered pin lines up with the count
    always_comb begin
        lvl_d = chan_level(cnt_nxt_i, cmp_nxt_i, top_nxt_i, pol_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    assign pwm_o = lvl_q;

endmodule

// File: rtl/btl_pwm_mod.sv
module btl_pwm_mod
    import btl_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SMP_W-1:0] smp_i,
    input  logic             smp_vld_i,
    input  logic [CNT_W-1:0] top_i,
    input  logic             pol_i,
    output logic             pwm_a_o,
    output logic             pwm_b_o,
    output logic             period_start_o
);

    localparam int unsigned NUM_CH = 2;

    cnt_t cnt_q;
    cnt_t top_q;
    cnt_t cnt_d;
    cnt_t top_d;
    logic wrap;
    cnt_t cmp_a_q;
    cnt_t cmp_b_q;
    cnt_t cmp_d [NUM_CH];
    logic pwm   [NUM_CH];
    pol_e pol;

    assign pol = pol_e'(pol_i);

    btl_pwm_timebase i_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .top_i     (top_i),
        .cnt_o     (cnt_q),
        .top_o     (top_q),
        .cnt_nxt_o (cnt_d),
        .top_nxt_o (top_d),
        .wrap_o    (wrap),
        .start_o   (period_start_o)
    );

    btl_pwm_shadow i_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_i       (smp_i),
        .vld_i       (smp_vld_i),
        .wrap_i      (wrap),
        .top_nxt_i   (top_d),
        .cmp_a_o     (cmp_a_q),
        .cmp_b_o     (cmp_b_q),
        .cmp_a_nxt_o (cmp_d[0]),
        .cmp_b_nxt_o (cmp_d[1])
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        btl_pwm_chan i_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt_nxt_i (cnt_d),
            .cmp_nxt_i (cmp_d[g]),
            .top_nxt_i (top_d),
            .pol_i     (pol),
            .pwm_o     (pwm[g])
        );
    end

    assign pwm_a_o = pwm[0];
    assign pwm_b_o = pwm[1];

endmodule

// File: rtl/btl_pwm_mod_chk.sv
module btl_pwm_mod_chk
    import btl_pwm_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input cnt_t cnt,
    input cnt_t top,
    input cnt_t cmp_a,
    input cnt_t cmp_b,
    input logic pol,
    input logic pwm_a,
    input logic pwm_b,
    input logic start
);

    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= 1'b1;
        end
    end

    // R1
    counter_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != top) |=> (cnt == $past(cnt) + cnt_t'(1)));

    // R1
    counter_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == top) |=> ((cnt == '0) && start));

    // R1
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (top != '0)) |=> !start);

    // R3
    cmp_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (({1'b0, cmp_a} + {1'b0, cmp_b}) == {1'b0, top}));

    // R7
    cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && (cnt != '0)) |-> ($stable(cmp_a) && $stable(cmp_b)));

    // R6
    sync_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && (cmp_a == cmp_b)) |-> (pwm_a == pwm_b));

    // R4
    full_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && (cmp_a == top) && !$past(pol)) |-> pwm_a);

    // R4
    zero_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && (cmp_a == '0) && (top != '0) && !$past(pol)) |-> !pwm_a);

endmodule

bind btl_pwm_mod btl_pwm_mod_chk i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   (cnt_q),
    .top   (top_q),
    .cmp_a (cmp_a_q),
    .cmp_b (cmp_b_q),
    .pol   (pol_i),
    .pwm_a (pwm_a_o),
    .pwm_b (pwm_b_o),
    .start (period_start_o)
);

// File: tb/test_btl_pwm_mod.sv
module test_btl_pwm_mod;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] smp_i = 8'd128;
    logic       smp_vld_i = 1'b0;
    logic [7:0] top_i = 8'd160;
    logic       pol_i = 1'b0;
    logic       pwm_a_o, pwm_b_o, period_start_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    btl_pwm_mod i_btl_pwm_mod (
        .clk            (clk),
        .rst_n          (rst_n),
        .smp_i          (smp_i),
        .smp_vld_i      (smp_vld_i),
        .top_i          (top_i),
        .pol_i          (pol_i),
        .pwm_a_o        (pwm_a_o),
        .pwm_b_o        (pwm_b_o),
        .period_start_o (period_start_o)
    );

    // top, pol, sample, expected A high cycles, expected B high cycles
    localparam int NVEC = 10;
    localparam int VEC [NVEC][5] = '{
        '{160, 0, 128,  80,  80},
        '{160, 0, 200, 125,  35},
        '{160, 0,  50,  31, 129},
        '{255, 0,  37,  37, 218},
        '{255, 0, 255, 256,   0},
        '{255, 0,   0,   0, 256},
        '{160, 1, 200,  36, 126},
        '{100, 0, 128,  50,  50},
        '{160, 1, 255,   0, 161},
        '{  8, 0, 192,   6,   2}
    };

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_start();
        @(negedge clk);
        while (!period_start_o) @(negedge clk);
    endtask

    // Called at a negedge where period_start_o is high; ends at the next such negedge
    task automatic measure(output int ha, output int hb, output int len, output int diff);
        ha = 0; hb = 0; len = 0; diff = 0;
        do begin
            ha   += int'(pwm_a_o);
            hb   += int'(pwm_b_o);
            diff += int'(pwm_a_o != pwm_b_o);
            len++;
            @(negedge clk);
        end while (!period_start_o && len < 1000);
    endtask

    task automatic load(int top, int pol, int smp);
        @(negedge clk);
        top_i     = 8'(top);
        pol_i     = 1'(pol);
        smp_i     = 8'(smp);
        smp_vld_i = 1'b1;
        @(negedge clk);
        smp_vld_i = 1'b0;
        wait_start();
        wait_start();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int ha, hb, len, diff;

        // R8: reset state
        repeat (3) @(negedge clk);
        check("R8", "pwm_a in reset", int'(pwm_a_o), 0);
        check("R8", "pwm_b in reset", int'(pwm_b_o), 0);
        check("R8", "period_start in reset", int'(period_start_o), 0);
        rst_n = 1'b1;

        // R8, R6: midscale shadow after reset, no sample offered
        wait_start();
        wait_start();
        measure(ha, hb, len, diff);
        check("R8", "A high after reset", ha, 80);
        check("R8", "B high after reset", hb, 80);
        check("R6", "A/B mismatch cycles at midscale", diff, 0);

        // R1: start pulse lasts one cycle
        @(negedge clk);
        check("R1", "period_start second cycle", int'(period_start_o), 0);

        // Table walk: R1 period length, R2/R4/R5 for A, R3/R4/R5 for B
        for (int v = 0; v < NVEC; v++) begin
            load(VEC[v][0], VEC[v][1], VEC[v][2]);
            measure(ha, hb, len, diff);
            check("R1", $sformatf("vec%0d period length", v), len, VEC[v][0] + 1);
            check(VEC[v][1] != 0 ? "R5" : "R2", $sformatf("vec%0d A high", v), ha, VEC[v][3]);
            check(VEC[v][1] != 0 ? "R5" : "R3", $sformatf("vec%0d B high", v), hb, VEC[v][4]);
            if (VEC[v][2] == 128 && VEC[v][0] % 2 == 0) begin
                check("R6", $sformatf("vec%0d A/B mismatch cycles", v), diff, 0);
            end
        end

        // R7: sample offered mid-period leaves the running period alone
        load(160, 0, 200);
        ha = 0; hb = 0; len = 0;
        do begin
            ha += int'(pwm_a_o);
            hb += int'(pwm_b_o);
            len++;
            if (len == 20) begin
                smp_i     = 8'd50;
                smp_vld_i = 1'b1;
            end else begin
                smp_vld_i = 1'b0;
            end
            @(negedge clk);
        end while (!period_start_o && len < 1000);
        smp_vld_i = 1'b0;
        check("R7", "A high in period with mid sample", ha, 125);
        check("R7", "B high in period with mid sample", hb, 35);
        measure(ha, hb, len, diff);
        check("R7", "A high after next wrap", ha, 31);
        check("R7", "B high after next wrap", hb, 129);

        summary();
        $finish;
    end

endmodule